// File: doc/BRIEF.md
# Add-Only Memory Command Engine with CRC-16

This block sequences byte-level commands for a one-time-programmable memory whose bits can only be cleared. It holds a data field of 64 pages of 32 bytes. It also holds a sparse status field with three small bitmap regions and one redirection byte per data page. Both fields come out of reset with every bit set. A bit-level layer above it passes in received bytes one at a time and asks for outgoing bytes one at a time. The engine reacts to the command byte and the two address bytes that follow it.

Read commands stream bytes and insert inverted CRC-16 checkpoints at fixed points. A plain read sends one CRC at the end of the field. A status read sends one CRC per 8-byte status page. An extended read returns a page's redirection byte and a CRC of it before each page, and a CRC of the page data after it. Write commands take one byte into a scratchpad and, for the non-fast codes, report a CRC. On a program strobe they AND the scratchpad into the target byte, unless a protect bit forbids it. They then return the stored byte and advance to the next address with a freshly seeded CRC.

Top module: `add_only_cmd_engine`

## Requirements
- R1: After a command byte, the next two received bytes are the address, low byte first. The effective address is that 16-bit value with bits 15..11 cleared. Every CRC covers the address bytes exactly as received.
- R2: Command F0h returns data bytes from the effective address up to 7FFh. It then returns the CRC over the command, the address bytes and all data returned, and after that only FFh until a bus reset.
- R3: Command AAh returns status bytes up to the end of the current 8-byte status page (address bits 2..0 all ones), then a CRC. The first CRC covers the command, the address and the data. Each later page CRC starts from zero and covers only that page. After the CRC of the page ending at 13Fh, only FFh follows.
- R4: Command A5h first returns the redirection byte of the addressed page, held at status address 100h plus the page number, followed by the CRC of the command, the address and that byte. It then returns data to the end of the 32-byte page, followed by a CRC of that data alone.
- R5: For each later page, A5h returns that page's redirection byte and a CRC of that byte alone, then the page data. After the CRC of page 63 it returns only FFh.
- R6: Commands 0Fh (data) and 55h (status) take one data byte into the scratchpad and return the CRC of the command, the address and the data. A program strobe then sets the target to old AND scratchpad, and the next byte returned is the stored value.
- R7: After the verify byte the address steps by one. The CRC is then loaded with the new address value, and the next data byte is shifted into it. After the verify byte at the last address of the field (7FFh for data, 13Fh for status), only FFh follows.
- R8: Commands F3h (data) and F5h (status) behave like 0Fh and 55h, but no CRC is returned between the data byte and the program strobe.
- R9: The CRC-16 uses polynomial x^16+x^15+x^2+1. Bits are shifted in LSB first, starting from zero unless seeded. It is sent inverted, low byte first.
- R10: A cleared bit p mod 8 of status byte p/8 (000h-007h) blocks programming of data page p. A cleared bit in 020h-027h blocks the redirection byte of that page in the same way.
- R11: The only implemented status locations are 000h-007h, 020h-027h, 040h-047h and 100h-13Fh. Any other status location reads FFh and ignores programming.
- R12: A bus_reset strobe aborts any command at once, and the next received byte is treated as a command.
- R13: An unknown command code makes every later requested byte FFh and ignores received bytes until bus_reset.
- R14: After reset tx_valid is low. Every tx_req cycle is answered by tx_valid with tx_byte in the following cycle. A request made where no byte is due returns FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; both memories return to all ones |
| bus_reset | input | 1 | Strobe that aborts the current command |
| rx_valid | input | 1 | Strobe: rx_byte holds a byte received from the bit layer |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Strobe: the bit layer needs the next byte to send |
| tx_valid | output | 1 | Marks tx_byte valid, one cycle after tx_req |
| tx_byte | output | 8 | Byte to send |
| prog_pulse | input | 1 | Strobe that stands for the programming pulse |

## Verification
A table of write transactions exercises the programming path under several patterns. These include a fresh byte, a second write over an existing byte (only the AND is visible), a protected page, a protected redirection byte, an unimplemented status hole, a truncated high address and the fast codes. Each pattern tells apart whether the verify byte follows the scratchpad, the old contents or neither. The read commands are then run against a shadow model built from those results. The runs use partial first pages, the last page and the last status page, so they show where each CRC checkpoint falls and what seed each CRC starts from. Directed cases cover auto-increment reseeding, the end of the field, abort mid-stream and an unknown command.

// File: rtl/aoe_pkg.sv
package aoe_pkg;

   typedef enum logic [3:0] {
      S_CMD, S_ALO, S_AHI, S_RDAT, S_RDIR, S_CRCL, S_CRCH,
      S_WDAT, S_PROG, S_VER, S_ONES, S_DEAD
   } aoe_state_e;

   typedef enum logic [1:0] {K_RDM, K_RDS, K_XRD, K_WR} aoe_kind_e;

   typedef struct packed {
      logic      ok;
      aoe_kind_e kind;
      logic      stat;
      logic      fast;
   } aoe_dec_t;

   localparam logic [7:0] OP_RD_DATA  = 8'hF0;
   localparam logic [7:0] OP_RD_STAT  = 8'hAA;
   localparam logic [7:0] OP_RD_EXT   = 8'hA5;
   localparam logic [7:0] OP_WR_DATA  = 8'h0F;
   localparam logic [7:0] OP_WR_STAT  = 8'h55;
   localparam logic [7:0] OP_WRF_DATA = 8'hF3;
   localparam logic [7:0] OP_WRF_STAT = 8'hF5;

   localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

   function automatic aoe_dec_t aoe_decode(input logic [7:0] op, input logic fast_ok);
      aoe_dec_t d;
      d = '{ok: 1'b0, kind: K_RDM, stat: 1'b0, fast: 1'b0};
      case (op)
         OP_RD_DATA:  d = '{ok: 1'b1, kind: K_RDM, stat: 1'b0, fast: 1'b0};
         OP_RD_STAT:  d = '{ok: 1'b1, kind: K_RDS, stat: 1'b1, fast: 1'b0};
         OP_RD_EXT:   d = '{ok: 1'b1, kind: K_XRD, stat: 1'b0, fast: 1'b0};
         OP_WR_DATA:  d = '{ok: 1'b1, kind: K_WR,  stat: 1'b0, fast: 1'b0};
         OP_WR_STAT:  d = '{ok: 1'b1, kind: K_WR,  stat: 1'b1, fast: 1'b0};
         OP_WRF_DATA: d = '{ok: fast_ok, kind: K_WR, stat: 1'b0, fast: 1'b1};
         OP_WRF_STAT: d = '{ok: fast_ok, kind: K_WR, stat: 1'b1, fast: 1'b1};
         default: ;
      endcase
      return d;
   endfunction

   function automatic logic [15:0] aoe_crc_step(input logic [15:0] c,
                                                input logic [7:0]  d,
                                                input logic [15:0] poly);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++)
         r = (r[0] ^ d[i]) ? ((r >> 1) ^ poly) : (r >> 1);
      return r;
   endfunction

endpackage

// File: rtl/aoe_crc16.sv
module aoe_crc16
   import aoe_pkg::*;
#(
   parameter logic [15:0] POLY = CRC_POLY_REFL
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        seed_en,
   input  logic [15:0] seed_val,
   input  logic        shift_en,
   input  logic [7:0]  shift_byte,
   output logic [15:0] crc
);
   logic [15:0] crc_q, base, nxt;

   always_comb begin
      base = seed_en ? seed_val : crc_q;
      nxt  = shift_en ? aoe_crc_step(base, shift_byte, POLY) : base;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) crc_q <= '0;
      else        crc_q <= nxt;

   assign crc = crc_q;
endmodule

// File: rtl/aoe_store.sv
module aoe_store #(
   parameter int PG_W = 6,
   parameter int PB_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_stat,
   input  logic [PG_W+PB_W-1:0] rd_addr,
   output logic [7:0]           rd_data,
   input  logic                 pg_en,
   input  logic                 pg_stat,
   input  logic [PG_W+PB_W-1:0] pg_addr,
   input  logic [7:0]           pg_val
);
   localparam int AW     = PG_W + PB_W;
   localparam int NPG    = 2 ** PG_W;
   localparam int PROT   = NPG / 8;
   localparam int STAT_N = 3 * PROT + NPG;
   localparam int IW     = $clog2(STAT_N);
   localparam logic [AW-1:0] WP_E = AW'(PROT);
   localparam logic [AW-1:0] RP_B = AW'(32);
   localparam logic [AW-1:0] RP_E = AW'(32 + PROT);
   localparam logic [AW-1:0] UB_B = AW'(64);
   localparam logic [AW-1:0] UB_E = AW'(64 + PROT);
   localparam logic [AW-1:0] RD_B = AW'(256);
   localparam logic [AW-1:0] RD_E = AW'(256 + NPG);

   generate
      if (PG_W < 3 || PG_W > 8 || AW < 9 || 256 + NPG > 2 ** AW) begin : g_bad_geom
         $error("aoe_store: page geometry does not fit the status layout");
      end
   endgenerate

   logic [7:0] dmem [2**AW];
   logic [7:0] smem [STAT_N];

   function automatic logic [IW:0] smap(input logic [AW-1:0] a);
      if (a < WP_E)              return {1'b1, IW'(a)};
      if (a >= RP_B && a < RP_E) return {1'b1, IW'(a - RP_B + AW'(PROT))};
      if (a >= UB_B && a < UB_E) return {1'b1, IW'(a - UB_B + AW'(2 * PROT))};
      if (a >= RD_B && a < RD_E) return {1'b1, IW'(a - RD_B + AW'(3 * PROT))};
      return '0;
   endfunction

   logic [IW:0]     rd_m, pg_m;
   logic [PG_W-1:0] pg_page, pg_rpage;
   logic            pg_is_redir, wp_blk, rp_blk;

   always_comb begin
      rd_m        = smap(rd_addr);
      pg_m        = smap(pg_addr);
      pg_page     = pg_addr[AW-1:PB_W];
      pg_rpage    = PG_W'(pg_addr - RD_B);
      pg_is_redir = (pg_addr >= RD_B) && (pg_addr < RD_E);
      wp_blk      = ~smem[IW'(pg_page >> 3)][pg_page[2:0]];
      rp_blk      = pg_is_redir && ~smem[IW'(PROT + (pg_rpage >> 3))][pg_rpage[2:0]];
      rd_data     = rd_stat ? (rd_m[IW] ? smem[rd_m[IW-1:0]] : 8'hFF) : dmem[rd_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dmem <= '{default: 8'hFF};
         smem <= '{default: 8'hFF};
      end else if (pg_en) begin
         if (!pg_stat) begin
            if (!wp_blk) dmem[pg_addr] <= dmem[pg_addr] & pg_val;
         end else if (pg_m[IW] && !rp_blk) begin
            smem[pg_m[IW-1:0]] <= smem[pg_m[IW-1:0]] & pg_val;
         end
      end
   end
endmodule

// File: rtl/add_only_cmd_engine.sv
module add_only_cmd_engine
   import aoe_pkg::*;
#(
   parameter int PG_W    = 6,
   parameter int PB_W    = 5,
   parameter int SP_W    = 3,
   parameter bit FAST_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_reset,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       tx_req,
   output logic       tx_valid,
   output logic [7:0] tx_byte,
   input  logic       prog_pulse
);
   localparam int AW = PG_W + PB_W;
   localparam logic [AW-1:0] A_MAX  = '1;
   localparam logic [AW-1:0] RD_B   = AW'(256);
   localparam logic [AW-1:0] ST_TOP = AW'(256 + 2 ** PG_W - 1);

   logic fast_ok;
   generate
      if (FAST_EN) begin : g_fast
         assign fast_ok = 1'b1;
      end else begin : g_nofast
         assign fast_ok = 1'b0;
      end
   endgenerate

   aoe_state_e  st_q, st_d;
   aoe_kind_e   kind_q, kind_d;
   logic        stat_q, stat_d, fast_q, fast_d, rph_q, rph_d;
   logic [AW-1:0] addr_q, addr_d, addr_inc;
   logic [7:0]  lo_q, lo_d, scr_q, scr_d, txb_q, txb_d;
   logic        txv_q, txv_d;
   logic        seed_en, sh_en, pg_en;
   logic [15:0] seed_val, crc;
   logic [7:0]  sh_byte, rd_data;
   logic        rd_stat;
   logic [AW-1:0] rd_addr;
   logic        dlast, slast, pend_d, pend_s, seg_end;
   aoe_dec_t    dec;

   aoe_crc16 u_crc (
      .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .seed_val(seed_val),
      .shift_en(sh_en), .shift_byte(sh_byte), .crc(crc)
   );

   aoe_store #(.PG_W(PG_W), .PB_W(PB_W)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .rd_addr(rd_addr), .rd_data(rd_data),
      .pg_en(pg_en), .pg_stat(stat_q), .pg_addr(addr_q), .pg_val(scr_q)
   );

   always_comb begin
      rd_stat  = (st_q == S_RDIR) | stat_q;
      rd_addr  = (st_q == S_RDIR) ? RD_B + (addr_q >> PB_W) : addr_q;
      addr_inc = addr_q + AW'(1);
      dlast    = addr_q == A_MAX;
      slast    = (addr_q == ST_TOP) || dlast;
      pend_d   = &addr_q[PB_W-1:0];
      pend_s   = &addr_q[SP_W-1:0];
      seg_end  = (kind_q == K_RDM) ? dlast : (kind_q == K_RDS) ? pend_s : pend_d;
   end

   always_comb begin
      st_d = st_q;  kind_d = kind_q;  stat_d = stat_q;  fast_d = fast_q;  rph_d = rph_q;
      addr_d = addr_q;  lo_d = lo_q;  scr_d = scr_q;
      txv_d = tx_req;  txb_d = 8'hFF;
      seed_en = 1'b0;  seed_val = '0;  sh_en = 1'b0;  sh_byte = rx_byte;  pg_en = 1'b0;
      dec = aoe_decode(rx_byte, fast_ok);
      if (bus_reset) st_d = S_CMD;
      else begin
         case (st_q)
            S_CMD: if (rx_valid) begin
               seed_en = 1'b1;  sh_en = 1'b1;
               kind_d = dec.kind;  stat_d = dec.stat;  fast_d = dec.fast;
               st_d = dec.ok ? S_ALO : S_DEAD;
            end
            S_ALO: if (rx_valid) begin
               sh_en = 1'b1;  lo_d = rx_byte;  st_d = S_AHI;
            end
            S_AHI: if (rx_valid) begin
               sh_en = 1'b1;  rph_d = 1'b0;  addr_d = AW'({rx_byte, lo_q});
               case (kind_q)
                  K_XRD:   st_d = S_RDIR;
                  K_WR:    st_d = S_WDAT;
                  default: st_d = S_RDAT;
               endcase
            end
            S_RDAT: if (tx_req) begin
               txb_d = rd_data;  sh_en = 1'b1;  sh_byte = rd_data;
               if (seg_end) st_d = S_CRCL;
               else         addr_d = addr_inc;
            end
            S_RDIR: if (tx_req) begin
               txb_d = rd_data;  sh_en = 1'b1;  sh_byte = rd_data;
               rph_d = 1'b1;  st_d = S_CRCL;
            end
            S_CRCL: if (tx_req) begin
               txb_d = ~crc[7:0];  st_d = S_CRCH;
            end
            S_CRCH: if (tx_req) begin
               txb_d = ~crc[15:8];
               case (kind_q)
                  K_WR:  st_d = S_PROG;
                  K_RDM: st_d = S_ONES;
                  K_RDS: if (slast) st_d = S_ONES;
                         else begin addr_d = addr_inc; seed_en = 1'b1; st_d = S_RDAT; end
                  K_XRD: if (rph_q) begin seed_en = 1'b1; rph_d = 1'b0; st_d = S_RDAT; end
                         else if (dlast) st_d = S_ONES;
                         else begin addr_d = addr_inc; seed_en = 1'b1; st_d = S_RDIR; end
               endcase
            end
            S_WDAT: if (rx_valid) begin
               scr_d = rx_byte;  sh_en = 1'b1;
               st_d = fast_q ? S_PROG : S_CRCL;
            end
            S_PROG: if (prog_pulse) begin
               pg_en = 1'b1;  st_d = S_VER;
            end
            S_VER: if (tx_req) begin
               txb_d = rd_data;
               if (stat_q ? slast : dlast) st_d = S_ONES;
               else begin
                  addr_d = addr_inc;  seed_en = 1'b1;  seed_val = 16'(addr_inc);  st_d = S_WDAT;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_CMD;  kind_q <= K_RDM;  stat_q <= 1'b0;  fast_q <= 1'b0;  rph_q <= 1'b0;
         addr_q <= '0;  lo_q <= '0;  scr_q <= 8'hFF;  txb_q <= 8'hFF;  txv_q <= 1'b0;
      end else begin
         st_q <= st_d;  kind_q <= kind_d;  stat_q <= stat_d;  fast_q <= fast_d;  rph_q <= rph_d;
         addr_q <= addr_d;  lo_q <= lo_d;  scr_q <= scr_d;  txb_q <= txb_d;  txv_q <= txv_d;
      end
   end

   assign tx_valid = txv_q;
   assign tx_byte  = txb_q;
endmodule

// File: rtl/aoe_chk.sv
module aoe_chk
   import aoe_pkg::*;
#(
   parameter int AW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_reset,
   input logic          tx_req,
   input logic          tx_valid,
   input logic [7:0]    tx_byte,
   input aoe_state_e    st,
   input logic [AW-1:0] addr
);
   a_r14_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> tx_valid);

   a_r14_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_req));

   a_r12_abort_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (st == S_CMD));

   a_r13_dead_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DEAD && !bus_reset) |=> (st == S_DEAD));

   a_r2_ones_tail: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ONES && tx_req) |=> (tx_byte == 8'hFF));

   a_r7_step_after_verify: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_VER && tx_req && !bus_reset) |=>
         (st == S_ONES || addr == $past(addr) + AW'(1)));
endmodule

bind add_only_cmd_engine aoe_chk #(.AW(PG_W + PB_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .tx_req(tx_req),
   .tx_valid(tx_valid), .tx_byte(tx_byte), .st(st_q), .addr(addr_q)
);

// File: tb/add_only_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module add_only_cmd_engine_tb_top;
   logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, rx_valid = 1'b0, tx_req = 1'b0, prog_pulse = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       tx_valid;
   logic [7:0] tx_byte;
   int n_cmp = 0, n_bad = 0;
   logic last_v;
   logic [7:0] m_data [0:2047];
   logic [7:0] m_stat [0:2047];

   always #4 clk = ~clk;

   add_only_cmd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte), .prog_pulse(prog_pulse)
   );

   // {command, address as sent, data, expected verify byte}
   localparam logic [39:0] WVEC [0:10] = '{
      {8'h0F, 16'h0041, 8'h5A, 8'h5A},   // R6 fresh byte
      {8'hF3, 16'h0041, 8'hF0, 8'h50},   // R8 fast code, AND with old
      {8'h55, 16'h0000, 8'hFE, 8'hFE},   // R10 protect page 0
      {8'h0F, 16'h0005, 8'h00, 8'hFF},   // R10 page 0 now blocked
      {8'h0F, 16'h0825, 8'h0F, 8'h0F},   // R1 top bits dropped -> 025h
      {8'h55, 16'h0101, 8'hFD, 8'hFD},   // R6 redirection of page 1
      {8'h55, 16'h0020, 8'hFD, 8'hFD},   // R10 lock redirection of page 1
      {8'h55, 16'h0101, 8'h00, 8'hFD},   // R10 locked redirection unchanged
      {8'h55, 16'h0010, 8'h00, 8'hFF},   // R11 hole in status map
      {8'hF5, 16'h0040, 8'h7F, 8'h7F},   // R8 fast status write
      {8'h0F, 16'h0030, 8'hA5, 8'hA5}    // R6 data page 1
   };

   function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] d);
      for (int i = 0; i < 8; i++) begin
         logic fb;
         fb = c[0] ^ d[i];
         c  = c >> 1;
         if (fb) c = c ^ 16'hA001;
      end
      return c;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic get(output logic [7:0] b);
      @(negedge clk); tx_req = 1'b1;
      @(negedge clk); tx_req = 1'b0; b = tx_byte; last_v = tx_valid;
   endtask

   task automatic breset();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
   endtask

   task automatic ppulse();
      @(negedge clk); prog_pulse = 1'b1;
      @(negedge clk); prog_pulse = 1'b0;
   endtask

   task automatic chk_crc(input string tag, input logic [15:0] c);
      logic [7:0] b;
      get(b); chk({tag, " crc lo"}, b, ~c[7:0]);
      get(b); chk({tag, " crc hi"}, b, ~c[15:8]);
   endtask

   task automatic start(input logic [7:0] cmd, input logic [15:0] a, output logic [15:0] c);
      breset();
      put(cmd); put(a[7:0]); put(a[15:8]);
      c = crc_b(crc_b(crc_b(16'h0000, cmd), a[7:0]), a[15:8]);
   endtask

   task automatic wr_txn(input logic [39:0] v);
      logic [15:0] c;
      logic [7:0] b;
      logic [7:0] cmd;
      cmd = v[39:32];
      start(cmd, v[31:16], c);
      put(v[15:8]);
      c = crc_b(c, v[15:8]);
      if (cmd == 8'h0F || cmd == 8'h55) chk_crc("R6 R9 write", c);
      ppulse();
      get(b); chk("R6 R10 R11 verify", b, v[7:0]);
      if (cmd == 8'h0F || cmd == 8'hF3) m_data[v[26:16]] = v[7:0];
      else                              m_stat[v[26:16]] = v[7:0];
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0]  b;
      logic [15:0] c;
      for (int i = 0; i < 2048; i++) begin m_data[i] = 8'hFF; m_stat[i] = 8'hFF; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R14 reset tx_valid", {7'b0, tx_valid}, 8'h00);
      get(b);
      chk("R14 idle byte", b, 8'hFF);
      chk("R14 answered", {7'b0, last_v}, 8'h01);

      for (int i = 0; i < 11; i++) wr_txn(WVEC[i[3:0]]);

      // R7: auto-increment reseeds the CRC with the new address
      start(8'h0F, 16'h0060, c);
      put(8'h11); c = crc_b(c, 8'h11); chk_crc("R7 first", c);
      ppulse(); get(b); chk("R7 verify first", b, 8'h11);
      put(8'h22); c = crc_b(16'h0061, 8'h22); chk_crc("R7 seeded", c);
      ppulse(); get(b); chk("R7 verify second", b, 8'h22);
      m_data[11'h060] = 8'h11; m_data[11'h061] = 8'h22;
      // R7: end of data field
      start(8'h0F, 16'h07FF, c);
      put(8'h80); c = crc_b(c, 8'h80); chk_crc("R7 end", c);
      ppulse(); get(b); chk("R7 verify end", b, 8'h80);
      m_data[11'h7FF] = 8'h80;
      get(b); chk("R7 after end", b, 8'hFF);

      // R2 R1: plain read from a truncated start address
      start(8'hF0, 16'h0841, c);
      for (int a = 16'h041; a <= 16'h7FF; a++) begin
         get(b); chk("R2 R1 data", b, m_data[a[10:0]]);
         c = crc_b(c, m_data[a[10:0]]);
      end
      chk_crc("R2 R9", c);
      get(b); chk("R2 tail", b, 8'hFF);
      get(b); chk("R2 tail again", b, 8'hFF);

      // R3: status read across two pages
      start(8'hAA, 16'h0002, c);
      for (int a = 2; a < 8; a++) begin
         get(b); chk("R3 page0", b, m_stat[a[10:0]]);
         c = crc_b(c, m_stat[a[10:0]]);
      end
      chk_crc("R3 first", c);
      c = 16'h0000;
      for (int a = 8; a < 16; a++) begin
         get(b); chk("R3 R11 page1", b, m_stat[a[10:0]]);
         c = crc_b(c, m_stat[a[10:0]]);
      end
      chk_crc("R3 later", c);
      // R3: last status page
      start(8'hAA, 16'h013C, c);
      for (int a = 16'h13C; a < 16'h140; a++) begin
         get(b); chk("R3 last page", b, m_stat[a[10:0]]);
         c = crc_b(c, m_stat[a[10:0]]);
      end
      chk_crc("R3 last", c);
      get(b); chk("R3 tail", b, 8'hFF);

      // R4 R5: extended read from page 1 into page 2
      start(8'hA5, 16'h0020, c);
      get(b); chk("R4 redirection", b, 8'hFD);
      c = crc_b(c, 8'hFD); chk_crc("R4 head", c);
      c = 16'h0000;
      for (int a = 16'h020; a < 16'h040; a++) begin
         get(b); chk("R4 data", b, m_data[a[10:0]]);
         c = crc_b(c, m_data[a[10:0]]);
      end
      chk_crc("R4 page", c);
      get(b); chk("R5 next redirection", b, m_stat[11'h102]);
      chk_crc("R5 redirection only", crc_b(16'h0000, m_stat[11'h102]));
      get(b); chk("R5 next data", b, m_data[11'h040]);
      // R5: last page then ones
      start(8'hA5, 16'h07E0, c);
      get(b); chk("R5 last redirection", b, m_stat[11'h13F]);
      c = crc_b(c, m_stat[11'h13F]); chk_crc("R5 last head", c);
      c = 16'h0000;
      for (int a = 16'h7E0; a < 16'h800; a++) begin
         get(b); chk("R5 last data", b, m_data[a[10:0]]);
         c = crc_b(c, m_data[a[10:0]]);
      end
      chk_crc("R5 last page", c);
      get(b); chk("R5 tail", b, 8'hFF);

      // R12: abort mid-stream
      start(8'hF0, 16'h0000, c);
      get(b); chk("R12 before abort", b, m_data[0]);
      start(8'hF0, 16'h0041, c);
      get(b); chk("R12 after abort", b, 8'h50);

      // R13: unknown command
      breset();
      put(8'h33); put(8'h30); put(8'h00);
      get(b); chk("R13 dead byte", b, 8'hFF);
      put(8'hF0);
      get(b); chk("R13 still dead", b, 8'hFF);
      start(8'hF0, 16'h0030, c);
      get(b); chk("R13 recovered", b, 8'hA5);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule